// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the scan timing for a raster display. A horizontal counter advances once per clock, where each clock is one character slot. A vertical counter advances once per scan line. From the two counts and a set of host-programmed compare values, the block decodes a horizontal sync, a vertical sync and a combined blanking signal. It also presents the raw counts so that a pixel fetch unit can follow the beam.

For each axis the host programs the last count value of the line or frame, where sync starts and how many counts it lasts, where blanking starts and ends, and the value the counter reloads when it wraps. A control register selects the sync polarity for each axis and gates both syncs onto the pins. Every host write lands in a pending copy. The whole pending set moves into the live set at the frame wrap, so a frame never mixes old and new timing.

Top module: `crt_timing_gen`

## Requirements
- R1: While `rst` is high, both counts equal their reset preload parameters (0 by default), all timing registers take their reset parameters, and the control register resets with both polarities negative and the sync gate closed, so both sync pins sit high.
- R2: When `xCount` is below the live horizontal length, it increments by one each cycle. A cycle with `xCount` at or above that length is a line wrap, and on the next cycle `xCount` equals the live horizontal preload (at a frame wrap, the pending one).
- R3: `yCount` changes only at a line wrap, where it increments by one. A line wrap with `yCount` at or above the live vertical length is a frame wrap, and `yCount` then loads the vertical preload.
- R4: An axis is in blanking when start ≤ end and start ≤ count ≤ end, or when start > end and either count ≥ start or count ≤ end. `blank` is high when either axis is in blanking.
- R5: An axis's sync is active while count ≥ sync start and count − sync start < sync width. A width of 0 never activates sync.
- R6: Control bit 0 (horizontal) and bit 1 (vertical) set to 1 select an active-low sync. The pin level is the active state XOR that bit.
- R7: While control bit 4 is 0, both sync pins stay at their inactive level, which equals the polarity bit.
- R8: A write with `wrEn` high updates the pending copy of the register at `wrAddr`: horizontal at 0 (length), 1 (sync start), 2 (sync width), 3 (blank start), 4 (blank end), 5 (preload); vertical at 8 to 13 in the same order; control at 15. Data is truncated to the field width. The live copy loads the whole pending set on the clock edge of a frame wrap and at no other edge.
- R9: Writes to addresses 6, 7 and 14 change no register and have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register address |
| wrData | input | DATA_W | Write data, DATA_W = max(HCNT_W, VCNT_W) |
| xCount | output | HCNT_W | Horizontal character count |
| yCount | output | VCNT_W | Vertical line count |
| hSync | output | 1 | Horizontal sync pin level |
| vSync | output | 1 | Vertical sync pin level |
| blank | output | 1 | Combined blanking |

## Verification
On every cycle, the assertions check how the counters step, wrap and reload. They also check that the live configuration holds still between frame wraps, and that a closed sync gate keeps both pins at their inactive level. The bench runs a cycle-level model built from the requirements and compares all five outputs every cycle. Only these scenarios can show the window decode (wrapped blanking ranges, zero-width sync, polarity changes), the deferral of a write until the frame ends, and that unmapped addresses are ignored.

// File: rtl/crt_timing_pkg.sv
package crt_timing_pkg;

  // Strobes from the control half to the counter half
  typedef struct packed {
    logic lineWrap;
    logic frameWrap;
  } crtStrobe_t;

  // Register map: one bank per axis, fields at fixed offsets
  localparam int H_BASE      = 0;
  localparam int V_BASE      = 8;
  localparam int REG_CTRL    = 15;
  localparam int OFS_LEN     = 0;
  localparam int OFS_SYNC    = 1;
  localparam int OFS_SWID    = 2;
  localparam int OFS_BSTART  = 3;
  localparam int OFS_BEND    = 4;
  localparam int OFS_PRE     = 5;
  localparam int NUM_FIELDS  = 6;

  // Control register bits
  localparam int CTRL_HNEG   = 0;
  localparam int CTRL_VNEG   = 1;
  localparam int CTRL_SYNCEN = 4;

endpackage

// File: rtl/crt_axis_regs.sv
module crt_axis_regs
  import crt_timing_pkg::*;
#(
  parameter int W          = 10,
  parameter int ADDR_W     = 4,
  parameter int BASE       = 0,
  parameter int LEN_RST    = 199,
  parameter int SYNC_RST   = 23,
  parameter int SWID_RST   = 12,
  parameter int BSTART_RST = 33,
  parameter int BEND_RST   = 193,
  parameter int PRE_RST    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [W-1:0]      wrData,
  input  logic              commit,
  output logic [W-1:0]      len,
  output logic [W-1:0]      syncStart,
  output logic [W-1:0]      syncWidth,
  output logic [W-1:0]      blankStart,
  output logic [W-1:0]      blankEnd,
  output logic [W-1:0]      pre,
  output logic [W-1:0]      pendPre
);

  localparam logic [NUM_FIELDS-1:0][W-1:0] RST_VAL = {
    W'(PRE_RST), W'(BEND_RST), W'(BSTART_RST),
    W'(SWID_RST), W'(SYNC_RST), W'(LEN_RST)
  };

  logic [NUM_FIELDS-1:0][W-1:0] pend;
  logic [NUM_FIELDS-1:0][W-1:0] live;

  // Pending bank: written by the host at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= RST_VAL;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (wrEn && (wrAddr == ADDR_W'(BASE + i))) begin
          pend[i] <= wrData;
        end
      end
    end
  end

  // Live bank: follows the pending bank only at frame wrap
  always_ff @(posedge clk) begin
    if (rst) begin
      live <= RST_VAL;
    end else if (commit) begin
      live <= pend;
    end
  end

  assign len        = live[OFS_LEN];
  assign syncStart  = live[OFS_SYNC];
  assign syncWidth  = live[OFS_SWID];
  assign blankStart = live[OFS_BSTART];
  assign blankEnd   = live[OFS_BEND];
  assign pre        = live[OFS_PRE];
  assign pendPre    = pend[OFS_PRE];

endmodule

// File: rtl/crt_timing_ctrl.sv
module crt_timing_ctrl
  import crt_timing_pkg::*;
#(
  parameter int HCNT_W       = 10,
  parameter int VCNT_W       = 11,
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 11,
  parameter int H_LEN_RST    = 199,
  parameter int H_SYNC_RST   = 23,
  parameter int H_SWID_RST   = 12,
  parameter int H_BSTART_RST = 33,
  parameter int H_BEND_RST   = 193,
  parameter int H_PRE_RST    = 0,
  parameter int V_LEN_RST    = 525,
  parameter int V_SYNC_RST   = 1,
  parameter int V_SWID_RST   = 2,
  parameter int V_BSTART_RST = 25,
  parameter int V_BEND_RST   = 505,
  parameter int V_PRE_RST    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [HCNT_W-1:0] xCount,
  input  logic [VCNT_W-1:0] yCount,
  output crtStrobe_t        strobe,
  output logic [HCNT_W-1:0] hLen,
  output logic [HCNT_W-1:0] hSyncStart,
  output logic [HCNT_W-1:0] hSyncWidth,
  output logic [HCNT_W-1:0] hBlankStart,
  output logic [HCNT_W-1:0] hBlankEnd,
  output logic [HCNT_W-1:0] hPre,
  output logic [HCNT_W-1:0] pendHPre,
  output logic [VCNT_W-1:0] vLen,
  output logic [VCNT_W-1:0] vSyncStart,
  output logic [VCNT_W-1:0] vSyncWidth,
  output logic [VCNT_W-1:0] vBlankStart,
  output logic [VCNT_W-1:0] vBlankEnd,
  output logic [VCNT_W-1:0] vPre,
  output logic [VCNT_W-1:0] pendVPre,
  output logic              hPolNeg,
  output logic              vPolNeg,
  output logic              syncEn
);

  localparam logic [2:0] CTL_RST = 3'b011;  // {syncEn, vNeg, hNeg}

  logic       lineWrap;
  logic       frameWrap;
  logic [2:0] pendCtl;
  logic [2:0] liveCtl;

  assign lineWrap  = (xCount >= hLen);
  assign frameWrap = lineWrap && (yCount >= vLen);
  assign strobe    = '{lineWrap: lineWrap, frameWrap: frameWrap};

  crt_axis_regs #(
    .W(HCNT_W), .ADDR_W(ADDR_W), .BASE(H_BASE),
    .LEN_RST(H_LEN_RST), .SYNC_RST(H_SYNC_RST), .SWID_RST(H_SWID_RST),
    .BSTART_RST(H_BSTART_RST), .BEND_RST(H_BEND_RST), .PRE_RST(H_PRE_RST)
  ) hRegs (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData[HCNT_W-1:0]), .commit(frameWrap),
    .len(hLen), .syncStart(hSyncStart), .syncWidth(hSyncWidth),
    .blankStart(hBlankStart), .blankEnd(hBlankEnd),
    .pre(hPre), .pendPre(pendHPre)
  );

  crt_axis_regs #(
    .W(VCNT_W), .ADDR_W(ADDR_W), .BASE(V_BASE),
    .LEN_RST(V_LEN_RST), .SYNC_RST(V_SYNC_RST), .SWID_RST(V_SWID_RST),
    .BSTART_RST(V_BSTART_RST), .BEND_RST(V_BEND_RST), .PRE_RST(V_PRE_RST)
  ) vRegs (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData[VCNT_W-1:0]), .commit(frameWrap),
    .len(vLen), .syncStart(vSyncStart), .syncWidth(vSyncWidth),
    .blankStart(vBlankStart), .blankEnd(vBlankEnd),
    .pre(vPre), .pendPre(pendVPre)
  );

  // Control register, deferred like the timing banks
  always_ff @(posedge clk) begin
    if (rst) begin
      pendCtl <= CTL_RST;
      liveCtl <= CTL_RST;
    end else begin
      if (frameWrap) begin
        liveCtl <= pendCtl;
      end
      if (wrEn && (wrAddr == ADDR_W'(REG_CTRL))) begin
        pendCtl <= {wrData[CTRL_SYNCEN], wrData[CTRL_VNEG], wrData[CTRL_HNEG]};
      end
    end
  end

  assign hPolNeg = liveCtl[0];
  assign vPolNeg = liveCtl[1];
  assign syncEn  = liveCtl[2];

endmodule

// File: rtl/crt_axis_decode.sv
module crt_axis_decode #(
  parameter int W = 10
) (
  input  logic [W-1:0] count,
  input  logic [W-1:0] syncStart,
  input  logic [W-1:0] syncWidth,
  input  logic [W-1:0] blankStart,
  input  logic [W-1:0] blankEnd,
  output logic         syncAct,
  output logic         blankAct
);

  logic [W-1:0] syncOfs;
  logic         blankFwd;

  assign syncOfs  = count - syncStart;
  assign syncAct  = (count >= syncStart) && (syncOfs < syncWidth);

  // A window whose start lies past its end wraps through the counter end
  assign blankFwd = (blankStart <= blankEnd);
  assign blankAct = blankFwd ? ((count >= blankStart) && (count <= blankEnd))
                             : ((count >= blankStart) || (count <= blankEnd));

endmodule

// File: rtl/crt_timing_dp.sv
module crt_timing_dp
  import crt_timing_pkg::*;
#(
  parameter int HCNT_W    = 10,
  parameter int VCNT_W    = 11,
  parameter int H_PRE_RST = 0,
  parameter int V_PRE_RST = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  crtStrobe_t        strobe,
  input  logic [HCNT_W-1:0] hSyncStart,
  input  logic [HCNT_W-1:0] hSyncWidth,
  input  logic [HCNT_W-1:0] hBlankStart,
  input  logic [HCNT_W-1:0] hBlankEnd,
  input  logic [HCNT_W-1:0] hPre,
  input  logic [HCNT_W-1:0] pendHPre,
  input  logic [VCNT_W-1:0] vSyncStart,
  input  logic [VCNT_W-1:0] vSyncWidth,
  input  logic [VCNT_W-1:0] vBlankStart,
  input  logic [VCNT_W-1:0] vBlankEnd,
  input  logic [VCNT_W-1:0] pendVPre,
  input  logic              hPolNeg,
  input  logic              vPolNeg,
  input  logic              syncEn,
  output logic [HCNT_W-1:0] xCount,
  output logic [VCNT_W-1:0] yCount,
  output logic              hSync,
  output logic              vSync,
  output logic              blank
);

  logic hSyncAct;
  logic vSyncAct;
  logic hBlankAct;
  logic vBlankAct;

  // Horizontal counter: one step per character clock
  always_ff @(posedge clk) begin
    if (rst) begin
      xCount <= HCNT_W'(H_PRE_RST);
    end else if (strobe.frameWrap) begin
      xCount <= pendHPre;
    end else if (strobe.lineWrap) begin
      xCount <= hPre;
    end else begin
      xCount <= xCount + HCNT_W'(1);
    end
  end

  // Vertical counter: one step per line
  always_ff @(posedge clk) begin
    if (rst) begin
      yCount <= VCNT_W'(V_PRE_RST);
    end else if (strobe.frameWrap) begin
      yCount <= pendVPre;
    end else if (strobe.lineWrap) begin
      yCount <= yCount + VCNT_W'(1);
    end
  end

  crt_axis_decode #(.W(HCNT_W)) hDec (
    .count(xCount), .syncStart(hSyncStart), .syncWidth(hSyncWidth),
    .blankStart(hBlankStart), .blankEnd(hBlankEnd),
    .syncAct(hSyncAct), .blankAct(hBlankAct)
  );

  crt_axis_decode #(.W(VCNT_W)) vDec (
    .count(yCount), .syncStart(vSyncStart), .syncWidth(vSyncWidth),
    .blankStart(vBlankStart), .blankEnd(vBlankEnd),
    .syncAct(vSyncAct), .blankAct(vBlankAct)
  );

  assign hSync = (syncEn & hSyncAct) ^ hPolNeg;
  assign vSync = (syncEn & vSyncAct) ^ vPolNeg;
  assign blank = hBlankAct | vBlankAct;

endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
  import crt_timing_pkg::*;
#(
  parameter int HCNT_W       = 10,
  parameter int VCNT_W       = 11,
  parameter int ADDR_W       = 4,
  parameter int H_LEN_RST    = 199,
  parameter int H_SYNC_RST   = 23,
  parameter int H_SWID_RST   = 12,
  parameter int H_BSTART_RST = 33,
  parameter int H_BEND_RST   = 193,
  parameter int H_PRE_RST    = 0,
  parameter int V_LEN_RST    = 525,
  parameter int V_SYNC_RST   = 1,
  parameter int V_SWID_RST   = 2,
  parameter int V_BSTART_RST = 25,
  parameter int V_BEND_RST   = 505,
  parameter int V_PRE_RST    = 0,
  localparam int DATA_W      = (HCNT_W > VCNT_W) ? HCNT_W : VCNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [HCNT_W-1:0] xCount,
  output logic [VCNT_W-1:0] yCount,
  output logic              hSync,
  output logic              vSync,
  output logic              blank
);

  crtStrobe_t        strobe;
  logic [HCNT_W-1:0] hLen, hSyncStart, hSyncWidth, hBlankStart, hBlankEnd;
  logic [HCNT_W-1:0] hPre, pendHPre;
  logic [VCNT_W-1:0] vLen, vSyncStart, vSyncWidth, vBlankStart, vBlankEnd;
  logic [VCNT_W-1:0] vPre, pendVPre;
  logic              hPolNeg, vPolNeg, syncEn;

  crt_timing_ctrl #(
    .HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .H_LEN_RST(H_LEN_RST), .H_SYNC_RST(H_SYNC_RST), .H_SWID_RST(H_SWID_RST),
    .H_BSTART_RST(H_BSTART_RST), .H_BEND_RST(H_BEND_RST), .H_PRE_RST(H_PRE_RST),
    .V_LEN_RST(V_LEN_RST), .V_SYNC_RST(V_SYNC_RST), .V_SWID_RST(V_SWID_RST),
    .V_BSTART_RST(V_BSTART_RST), .V_BEND_RST(V_BEND_RST), .V_PRE_RST(V_PRE_RST)
  ) ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .xCount(xCount), .yCount(yCount), .strobe(strobe),
    .hLen(hLen), .hSyncStart(hSyncStart), .hSyncWidth(hSyncWidth),
    .hBlankStart(hBlankStart), .hBlankEnd(hBlankEnd), .hPre(hPre), .pendHPre(pendHPre),
    .vLen(vLen), .vSyncStart(vSyncStart), .vSyncWidth(vSyncWidth),
    .vBlankStart(vBlankStart), .vBlankEnd(vBlankEnd), .vPre(vPre), .pendVPre(pendVPre),
    .hPolNeg(hPolNeg), .vPolNeg(vPolNeg), .syncEn(syncEn)
  );

  crt_timing_dp #(
    .HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .H_PRE_RST(H_PRE_RST), .V_PRE_RST(V_PRE_RST)
  ) dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .hSyncStart(hSyncStart), .hSyncWidth(hSyncWidth),
    .hBlankStart(hBlankStart), .hBlankEnd(hBlankEnd),
    .hPre(hPre), .pendHPre(pendHPre),
    .vSyncStart(vSyncStart), .vSyncWidth(vSyncWidth),
    .vBlankStart(vBlankStart), .vBlankEnd(vBlankEnd),
    .pendVPre(pendVPre),
    .hPolNeg(hPolNeg), .vPolNeg(vPolNeg), .syncEn(syncEn),
    .xCount(xCount), .yCount(yCount),
    .hSync(hSync), .vSync(vSync), .blank(blank)
  );

endmodule

// File: rtl/crt_timing_gen_chk.sv
module crt_timing_gen_chk #(
  parameter int HCNT_W = 10,
  parameter int VCNT_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              lineWrap,
  input logic              frameWrap,
  input logic [HCNT_W-1:0] xCount,
  input logic [VCNT_W-1:0] yCount,
  input logic [HCNT_W-1:0] hLen,
  input logic [VCNT_W-1:0] vLen,
  input logic [HCNT_W-1:0] hPre,
  input logic [HCNT_W-1:0] pendHPre,
  input logic [VCNT_W-1:0] pendVPre,
  input logic              hPolNeg,
  input logic              vPolNeg,
  input logic              syncEn,
  input logic              hSync,
  input logic              vSync
);

  assert_x_step_R2: assert property (@(posedge clk) disable iff (rst)
    !lineWrap |=> xCount == $past(xCount) + HCNT_W'(1));

  assert_x_reload_R2: assert property (@(posedge clk) disable iff (rst)
    (lineWrap && !frameWrap) |=> xCount == $past(hPre));

  assert_y_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !lineWrap |=> $stable(yCount));

  assert_y_step_R3: assert property (@(posedge clk) disable iff (rst)
    (lineWrap && !frameWrap) |=> yCount == $past(yCount) + VCNT_W'(1));

  assert_frame_reload_R8: assert property (@(posedge clk) disable iff (rst)
    frameWrap |=> (xCount == $past(pendHPre)) && (yCount == $past(pendVPre)));

  assert_live_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !frameWrap |=> $stable(hLen) && $stable(vLen) && $stable(syncEn)
                   && $stable(hPolNeg) && $stable(vPolNeg));

  assert_sync_gated_R7: assert property (@(posedge clk) disable iff (rst)
    !syncEn |-> (hSync == hPolNeg) && (vSync == vPolNeg));

endmodule

bind crt_timing_gen crt_timing_gen_chk #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) chkInst (
  .clk(clk), .rst(rst),
  .lineWrap(strobe.lineWrap), .frameWrap(strobe.frameWrap),
  .xCount(xCount), .yCount(yCount), .hLen(hLen), .vLen(vLen),
  .hPre(hPre), .pendHPre(pendHPre), .pendVPre(pendVPre),
  .hPolNeg(hPolNeg), .vPolNeg(vPolNeg), .syncEn(syncEn),
  .hSync(hSync), .vSync(vSync)
);

// File: tb/crt_timing_gen_test.sv
`timescale 1ns/1ps
module crt_timing_gen_test;

  localparam int HW = 10;
  localparam int VW = 11;
  localparam int AW = 4;
  localparam int DW = 11;
  localparam int HL = 19, HS = 3, HSW = 4, HBS = 14, HBE = 19, HP = 0;
  localparam int VL = 9,  VS = 2, VSW = 1, VBS = 8,  VBE = 9,  VP = 0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [HW-1:0] xCount;
  logic [VW-1:0] yCount;
  logic          hSync, vSync, blank;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  running = 1'b0;
  bit  done    = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  crt_timing_gen #(
    .HCNT_W(HW), .VCNT_W(VW), .ADDR_W(AW),
    .H_LEN_RST(HL), .H_SYNC_RST(HS), .H_SWID_RST(HSW),
    .H_BSTART_RST(HBS), .H_BEND_RST(HBE), .H_PRE_RST(HP),
    .V_LEN_RST(VL), .V_SYNC_RST(VS), .V_SWID_RST(VSW),
    .V_BSTART_RST(VBS), .V_BEND_RST(VBE), .V_PRE_RST(VP)
  ) uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .xCount(xCount), .yCount(yCount), .hSync(hSync), .vSync(vSync), .blank(blank)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  // field index: 0 len, 1 sync start, 2 sync width, 3 blank start, 4 blank end, 5 preload
  int mx, my;
  int pH[6], aH[6], pV[6], aV[6];
  int pC, aC;
  bit lw, fw;

  function automatic bit inBlank(int c, int s, int e);
    return (s <= e) ? (c >= s && c <= e) : (c >= s || c <= e);
  endfunction

  function automatic bit inSync(int c, int s, int w);
    return (c >= s) && ((c - s) < w);
  endfunction

  function automatic bit expSync(int c, int s, int w, bit en, bit neg);
    return (en && inSync(c, s, w)) ^ neg;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mx <= HP; my <= VP;
      pH <= '{HL, HS, HSW, HBS, HBE, HP}; aH <= '{HL, HS, HSW, HBS, HBE, HP};
      pV <= '{VL, VS, VSW, VBS, VBE, VP}; aV <= '{VL, VS, VSW, VBS, VBE, VP};
      pC <= 3; aC <= 3;
    end else begin
      lw = (mx >= aH[0]);
      fw = lw && (my >= aV[0]);
      if (fw) begin
        mx <= pH[5]; my <= pV[5];
        aH <= pH; aV <= pV; aC <= pC;
      end else if (lw) begin
        mx <= aH[5]; my <= my + 1;
      end else begin
        mx <= mx + 1;
      end
      if (wrEn) begin
        if (wrAddr <= 5)                     pH[wrAddr]     <= int'(wrData) & 32'h3FF;
        else if (wrAddr >= 8 && wrAddr <= 13) pV[wrAddr - 8] <= int'(wrData) & 32'h7FF;
        else if (wrAddr == 15)               pC <= (int'(wrData) & 3) | (((int'(wrData) >> 4) & 1) << 2);
      end
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (running && !rst) begin
      chk(int'(xCount) == mx, "R2 xCount", int'(xCount), mx);
      chk(int'(yCount) == my, "R3 yCount", int'(yCount), my);
      chk(blank == (inBlank(mx, aH[3], aH[4]) || inBlank(my, aV[3], aV[4])),
          "R4 blank", int'(blank), int'(inBlank(mx, aH[3], aH[4]) || inBlank(my, aV[3], aV[4])));
      chk(hSync == expSync(mx, aH[1], aH[2], aC[2], aC[0]), "R5 R6 R7 hSync",
          int'(hSync), int'(expSync(mx, aH[1], aH[2], aC[2], aC[0])));
      chk(vSync == expSync(my, aV[1], aV[2], aC[2], aC[1]), "R5 R6 R7 vSync",
          int'(vSync), int'(expSync(my, aV[1], aV[2], aC[2], aC[1])));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int addr, int data);
    wrEn = 1'b1; wrAddr = AW'(addr); wrData = DW'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkLine(int expLen, int expPre, string tag);
    int guard = 0;
    while (int'(xCount) != expLen && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    chk(int'(xCount) == expPre, tag, int'(xCount), expPre);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(xCount == 0, "R1 xCount reset", int'(xCount), 0);
    chk(yCount == 0, "R1 yCount reset", int'(yCount), 0);
    chk(hSync == 1'b1, "R1 hSync idle high", int'(hSync), 1);
    chk(vSync == 1'b1, "R1 vSync idle high", int'(vSync), 1);
    chk(blank == 1'b0, "R1 blank at origin", int'(blank), 0);
    rst = 1'b0;
    running = 1'b1;

    // R7: gate closed for a full frame of default timing
    repeat (250) @(negedge clk);

    // R6/R7: open gate, horizontal active-high, vertical active-low
    wr(15, 32'h12);
    for (int i = 0; i < 4; i++) begin
      chk(hSync == 1'b1, "R8 pending control not yet live", int'(hSync), 1);
      @(negedge clk);
    end
    repeat (220) @(negedge clk);

    // R8: new length deferred until the frame ends
    wr(0, 9);
    checkLine(HL, HP, "R8 old length kept within frame");
    repeat (220) @(negedge clk);
    checkLine(9, HP, "R8 new length live after frame wrap");

    // R9: unmapped addresses
    wr(6, 3);
    wr(7, 1);
    wr(14, 0);
    repeat (220) @(negedge clk);
    checkLine(9, HP, "R9 unmapped writes ignored");

    // R4/R5/R2 corners: wrapped blank window, zero sync width, preloads
    wr(3, 7);
    wr(4, 3);
    wr(2, 0);
    wr(5, 2);
    wr(13, 1);
    repeat (220) @(negedge clk);
    checkLine(9, 2, "R2 line reload to preload");
    for (int i = 0; i < 30; i++) begin
      chk(hSync == 1'b0, "R5 zero width never active", int'(hSync), 0);
      @(negedge clk);
    end
    while (!(xCount == 3 && yCount < 8)) @(negedge clk);
    chk(blank == 1'b1, "R4 wrapped window low side", int'(blank), 1);
    @(negedge clk);
    chk(blank == 1'b0, "R4 wrapped window gap", int'(blank), 0);

    // Random register traffic
    for (int it = 0; it < 40; it++) begin
      int a = $urandom_range(0, 15);
      int d;
      if (a == 0)       d = $urandom_range(4, 30);
      else if (a == 8)  d = $urandom_range(3, 15);
      else if (a == 15) d = $urandom_range(0, 255);
      else              d = $urandom_range(0, 20);
      wr(a, d);
      repeat ($urandom_range(0, 120)) @(negedge clk);
    end
    repeat (500) @(negedge clk);

    running = 1'b0;
    finishRun();
  end

endmodule